// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block derives the raster timing for a flat panel, active or passive, from four 32-bit control words. Software writes them through a small register port. A divider produces the pixel-rate tick. A horizontal position counter advances once per tick, and a vertical counter advances once per completed line. Sync pulses, a data-valid strobe and the pixel and line indices inside the visible window are decoded from those two counters.

Each line is laid out as four phases in this order: sync pulse, leading wait, visible pixels, trailing wait. A frame uses the same four phases, counted in lines. Most length fields are stored with a bias, and the decode logic removes it. Writes to the timing words go into a staging copy. The staging copy moves into the working copy only while the generator is stopped or at the instant a frame ends, so a frame never mixes two timings.

Top module: `lcd_timing_gen`

## Requirements
- R1: While enable (control word bit 0) is clear, including after reset, pclk_en, de, pix_x and line_y are 0, hsync and vsync sit at their inactive level, and pclk_out rests at the edge-select level.
- R2: pclk_en pulses for one clock every 2*D+4 clocks, where D is bits 7:0 of the clock word (address 3), counting from the cycle that enable takes effect.
- R3: A line is HS+HB+HA+HE pixel ticks long. HS = bits 15:10 + 1, HE = bits 23:16 + 1 and HB = bits 31:24 + 1 of the horizontal word (address 1). hsync is active for the first HS ticks of each line.
- R4: The visible part of a line is bits 9:0 + 16 ticks long and starts after HS+HB ticks. pix_x counts 0 upward across it and is 0 elsewhere.
- R5: A frame is VS+VB+VA+VE lines long. VA = bits 9:0 + 1 and VS = bits 15:10 + 1 of the vertical word (address 2). VE = bits 23:16 and VB = bits 31:24 are used unbiased, so 0 means no wait lines. vsync is active for the first VS lines, and line_y counts the visible lines from 0.
- R6: de is high only when the horizontal and vertical positions are both inside their visible windows.
- R7: Clock word bit 21 sets the active level of hsync and bit 20 sets the active level of vsync. In both bits, 0 means active low and 1 means active high.
- R8: pclk_out is low for the first half of each pixel period and high for the second half when clock word bit 22 is 0. It is inverted when that bit is 1.
- R9: A write to address 1, 2 or 3 while running leaves the frame in progress unchanged. The new timing applies from the next frame start.
- R10: panel_active follows control word bit 7 from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Word select: 0 control, 1 horizontal, 2 vertical, 3 clock |
| cfg_wdata | input | 32 | Write data |
| pclk_en | output | 1 | One-clock pixel tick |
| pclk_out | output | 1 | Pixel clock waveform |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data valid |
| pix_x | output | 11 | Visible pixel index |
| line_y | output | 11 | Visible line index |
| panel_active | output | 1 | Active-panel mode select |

## Verification
The assertions check the following on every cycle: the divider stays below its ratio, ticks never come back to back, both position counters stay inside their programmed totals, and the generator is silent while stopped. They also check that pix_x only moves on a tick, that line_y only moves at a line end, and that the working timing copy holds steady between frame boundaries. Only the bench scenarios can show that the biased fields decode to the right phase lengths and that each polarity and edge setting reaches the pins. The same holds for a write made in the middle of a frame taking effect at the following frame rather than at once.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  localparam int CNT_W = 12;
  localparam int PIX_W = 11;

  localparam int HPOL_BIT = 21;
  localparam int VPOL_BIT = 20;
  localparam int EDGE_BIT = 22;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_HORIZ = 2'd1,
    SEL_VERT  = 2'd2,
    SEL_CLOCK = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] sync_len;
    logic [CNT_W-1:0] lead_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] tail_len;
  } axis_cfg_t;

  // Horizontal word: every length is stored as count-1, except the visible width, which is stored as count-16.
  function automatic axis_cfg_t decode_horiz(input logic [31:0] w);
    axis_cfg_t a;
    a.sync_len = CNT_W'(w[15:10]) + CNT_W'(1);
    a.lead_len = CNT_W'(w[31:24]) + CNT_W'(1);
    a.act_len  = CNT_W'(w[9:0])   + CNT_W'(16);
    a.tail_len = CNT_W'(w[23:16]) + CNT_W'(1);
    return a;
  endfunction

  // Vertical word: sync and visible lines are stored as count-1, and both waits are stored as plain counts.
  function automatic axis_cfg_t decode_vert(input logic [31:0] w);
    axis_cfg_t a;
    a.sync_len = CNT_W'(w[15:10]) + CNT_W'(1);
    a.lead_len = CNT_W'(w[31:24]);
    a.act_len  = CNT_W'(w[9:0])   + CNT_W'(1);
    a.tail_len = CNT_W'(w[23:16]);
    return a;
  endfunction

endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg
  import lcd_tg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  cfg_sel_e    wr_sel,
  input  logic [31:0] wr_data,
  input  logic        frame_wrap,
  output logic        enable,
  output logic        active_mode,
  output logic [31:0] horiz_word,
  output logic [31:0] vert_word,
  output logic [31:0] clock_word
);

  logic        en_q, en_d, mode_q, mode_d;
  logic [31:0] stg_h_q, stg_h_d, stg_v_q, stg_v_d, stg_c_q, stg_c_d;
  logic [31:0] wrk_h_q, wrk_h_d, wrk_v_q, wrk_v_d, wrk_c_q, wrk_c_d;
  logic        take;

  always_comb begin
    en_d    = en_q;
    mode_d  = mode_q;
    stg_h_d = stg_h_q;
    stg_v_d = stg_v_q;
    stg_c_d = stg_c_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_CTRL:  begin
          en_d   = wr_data[0];
          mode_d = wr_data[7];
        end
        SEL_HORIZ: stg_h_d = wr_data;
        SEL_VERT:  stg_v_d = wr_data;
        SEL_CLOCK: stg_c_d = wr_data;
        default:   ;
      endcase
    end
    // The working copy follows staging while stopped and reloads at each frame boundary.
    take    = !en_q || frame_wrap;
    wrk_h_d = take ? stg_h_q : wrk_h_q;
    wrk_v_d = take ? stg_v_q : wrk_v_q;
    wrk_c_d = take ? stg_c_q : wrk_c_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      stg_h_q <= '0;
      stg_v_q <= '0;
      stg_c_q <= '0;
      wrk_h_q <= '0;
      wrk_v_q <= '0;
      wrk_c_q <= '0;
    end else begin
      en_q    <= en_d;
      mode_q  <= mode_d;
      stg_h_q <= stg_h_d;
      stg_v_q <= stg_v_d;
      stg_c_q <= stg_c_d;
      wrk_h_q <= wrk_h_d;
      wrk_v_q <= wrk_v_d;
      wrk_c_q <= wrk_c_d;
    end
  end

  assign enable      = en_q;
  assign active_mode = mode_q;
  assign horiz_word  = wrk_h_q;
  assign vert_word   = wrk_v_q;
  assign clock_word  = wrk_c_q;

  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && !$past(frame_wrap)) |->
      ($stable(wrk_h_q) && $stable(wrk_v_q) && $stable(wrk_c_q))); // R9

endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_code,
  input  logic             edge_sel,
  output logic             pclk_en,
  output logic             pclk_out
);

  localparam int RW = DIV_W + 2;

  logic [RW-1:0] ratio, half, cnt_q, cnt_d;
  logic          last;

  always_comb begin
    ratio = {1'b0, div_code, 1'b0} + RW'(4);
    half  = ratio >> 1;
    last  = (cnt_q == ratio - RW'(1));
    if (!enable)   cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pclk_en  = enable && last;
  assign pclk_out = enable ? ((cnt_q >= half) ^ edge_sel) : edge_sel;

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (cnt_q < ratio)); // R2

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |=> !pclk_en); // R2

endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int CNT_W = 12,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [CNT_W-1:0] lead_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] tail_len,
  output logic             wrap,
  output logic             in_sync,
  output logic             in_act,
  output logic [IDX_W-1:0] idx
);

  logic [CNT_W-1:0] pos_q, pos_d, total, act_start, act_end;
  logic             last;

  always_comb begin
    total     = sync_len + lead_len + act_len + tail_len;
    act_start = sync_len + lead_len;
    act_end   = act_start + act_len;
    last      = (pos_q == total - CNT_W'(1));
    wrap      = step && last;
    if (!enable)   pos_d = '0;
    else if (wrap) pos_d = '0;
    else if (step) pos_d = pos_q + CNT_W'(1);
    else           pos_d = pos_q;
    in_sync = enable && (pos_q < sync_len);
    in_act  = enable && (pos_q >= act_start) && (pos_q < act_end);
    idx     = in_act ? IDX_W'(pos_q - act_start) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (pos_q < total)); // R3

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pos_q == '0)); // R3

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic             pclk_en,
  output logic             pclk_out,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix_x,
  output logic [PIX_W-1:0] line_y,
  output logic             panel_active
);

  logic [1:0]  rsync_q;
  logic        rst_core_n;
  logic        enable;
  logic [31:0] horiz_word, vert_word, clock_word;
  axis_cfg_t   hcfg, vcfg;
  logic        h_wrap, h_sync, h_act, v_wrap, v_sync, v_act;
  logic        hpol, vpol;

  // Reset asserts at once and releases through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  lcd_tg_cfg i_cfg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (cfg_we),
    .wr_sel     (cfg_sel_e'(cfg_addr)),
    .wr_data    (cfg_wdata),
    .frame_wrap (v_wrap),
    .enable     (enable),
    .active_mode(panel_active),
    .horiz_word (horiz_word),
    .vert_word  (vert_word),
    .clock_word (clock_word)
  );

  assign hcfg = decode_horiz(horiz_word);
  assign vcfg = decode_vert(vert_word);
  assign hpol = clock_word[HPOL_BIT];
  assign vpol = clock_word[VPOL_BIT];

  lcd_tg_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .enable  (enable),
    .div_code(clock_word[DIV_W-1:0]),
    .edge_sel(clock_word[EDGE_BIT]),
    .pclk_en (pclk_en),
    .pclk_out(pclk_out)
  );

  lcd_tg_axis #(.CNT_W(CNT_W), .IDX_W(PIX_W)) i_haxis (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .enable  (enable),
    .step    (pclk_en),
    .sync_len(hcfg.sync_len),
    .lead_len(hcfg.lead_len),
    .act_len (hcfg.act_len),
    .tail_len(hcfg.tail_len),
    .wrap    (h_wrap),
    .in_sync (h_sync),
    .in_act  (h_act),
    .idx     (pix_x)
  );

  lcd_tg_axis #(.CNT_W(CNT_W), .IDX_W(PIX_W)) i_vaxis (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .enable  (enable),
    .step    (h_wrap),
    .sync_len(vcfg.sync_len),
    .lead_len(vcfg.lead_len),
    .act_len (vcfg.act_len),
    .tail_len(vcfg.tail_len),
    .wrap    (v_wrap),
    .in_sync (v_sync),
    .in_act  (v_act),
    .idx     (line_y)
  );

  assign hsync = h_sync ? hpol : !hpol;
  assign vsync = v_sync ? vpol : !vpol;
  assign de    = h_act && v_act;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    !enable |-> (!de && !pclk_en && pix_x == '0 && line_y == '0)); // R1

  AST_DE_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(de) |-> (pix_x == '0)); // R4

  AST_PIX_ON_TICK: assert property (@(posedge clk) disable iff (!rst_core_n)
    (de && $past(de) && !$past(pclk_en)) |-> $stable(pix_x)); // R4

  AST_LINE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (enable && $past(enable) && !$past(h_wrap)) |-> $stable(line_y)); // R5

endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  import lcd_tg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic pclk_en, pclk_out, hsync, vsync, de, panel_active;
  logic [PIX_W-1:0] pix_x, line_y;

  always #4 clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pclk_en(pclk_en), .pclk_out(pclk_out),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x),
    .line_y(line_y), .panel_active(panel_active)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string tag_force = "";

  // Reference state: staged (s_) and working (l_) timing, held as decoded counts.
  int m_en = 0, m_mode = 0;
  int s_hs = 1, s_hb = 1, s_ha = 16, s_hf = 1, s_vs = 1, s_vb = 0, s_va = 1, s_vf = 0;
  int s_div = 4, s_vpol = 0, s_hpol = 0, s_edge = 0;
  int l_hs = 1, l_hb = 1, l_ha = 16, l_hf = 1, l_vs = 1, l_vb = 0, l_va = 1, l_vf = 0;
  int l_div = 4, l_vpol = 0, l_hpol = 0, l_edge = 0;
  int md = 0, mh = 0, mv = 0;

  bit p_we = 0;
  int p_addr = 0, p_a = 0, p_b = 0, p_c = 0, p_d = 0;
  logic [31:0] p_word = '0;

  task automatic chk(string tag, string what, int got, int exp);
    string t;
    t = (tag_force != "") ? tag_force : tag;
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", t, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    int e_pen, e_pout, hs_on, vs_on, h_in, v_in, e_px, e_ly;
    e_pen  = (m_en != 0 && md == l_div - 1) ? 1 : 0;
    e_pout = (m_en != 0) ? (((md >= l_div / 2) ? 1 : 0) ^ l_edge) : l_edge;
    hs_on  = (m_en != 0 && mh < l_hs) ? 1 : 0;
    vs_on  = (m_en != 0 && mv < l_vs) ? 1 : 0;
    h_in   = (m_en != 0 && mh >= l_hs + l_hb && mh < l_hs + l_hb + l_ha) ? 1 : 0;
    v_in   = (m_en != 0 && mv >= l_vs + l_vb && mv < l_vs + l_vb + l_va) ? 1 : 0;
    e_px   = h_in ? mh - (l_hs + l_hb) : 0;
    e_ly   = v_in ? mv - (l_vs + l_vb) : 0;
    chk("R2", "pclk_en", int'(pclk_en), e_pen);
    chk("R8", "pclk_out", int'(pclk_out), e_pout);
    chk(l_hpol != 0 ? "R7" : "R3", "hsync", int'(hsync), hs_on ? l_hpol : 1 - l_hpol);
    chk(l_vpol != 0 ? "R7" : "R5", "vsync", int'(vsync), vs_on ? l_vpol : 1 - l_vpol);
    chk("R4", "pix_x", int'(pix_x), e_px);
    chk("R5", "line_y", int'(line_y), e_ly);
    chk("R6", "de", int'(de), h_in & v_in);
    chk("R10", "panel_active", int'(panel_active), m_mode);
  endtask

  task automatic model_edge();
    bit wrap_f;
    wrap_f = 0;
    if (m_en != 0) begin
      if (md == l_div - 1) begin
        md = 0;
        if (mh == l_hs + l_hb + l_ha + l_hf - 1) begin
          mh = 0;
          if (mv == l_vs + l_vb + l_va + l_vf - 1) begin
            mv = 0;
            wrap_f = 1;
          end else mv++;
        end else mh++;
      end else md++;
    end else begin
      md = 0; mh = 0; mv = 0;
    end
    if (m_en == 0 || wrap_f) begin
      l_hs = s_hs; l_hb = s_hb; l_ha = s_ha; l_hf = s_hf;
      l_vs = s_vs; l_vb = s_vb; l_va = s_va; l_vf = s_vf;
      l_div = s_div; l_vpol = s_vpol; l_hpol = s_hpol; l_edge = s_edge;
    end
    if (p_we) begin
      case (p_addr)
        0: begin m_en = p_a; m_mode = p_b; end
        1: begin s_hs = p_a; s_hb = p_b; s_ha = p_c; s_hf = p_d; end
        2: begin s_vs = p_a; s_vb = p_b; s_va = p_c; s_vf = p_d; end
        default: begin s_div = p_a; s_vpol = p_b; s_hpol = p_c; s_edge = p_d; end
      endcase
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    cfg_we    = p_we;
    cfg_addr  = 2'(p_addr);
    cfg_wdata = p_word;
    model_edge();
    p_we = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctrl(int en, int mode);
    p_we = 1; p_addr = 0; p_a = en; p_b = mode;
    p_word = 32'(en) | (32'(mode) << 7);
    step();
  endtask

  task automatic wr_h(int hs, int hb, int ha, int hf);
    p_we = 1; p_addr = 1; p_a = hs; p_b = hb; p_c = ha; p_d = hf;
    p_word = 32'(ha - 16) | (32'(hs - 1) << 10) | (32'(hf - 1) << 16) | (32'(hb - 1) << 24);
    step();
  endtask

  task automatic wr_v(int vs, int vb, int va, int vf);
    p_we = 1; p_addr = 2; p_a = vs; p_b = vb; p_c = va; p_d = vf;
    p_word = 32'(va - 1) | (32'(vs - 1) << 10) | (32'(vf) << 16) | (32'(vb) << 24);
    step();
  endtask

  task automatic wr_c(int dv, int vp, int hp, int ed);
    p_we = 1; p_addr = 3; p_a = dv; p_b = vp; p_c = hp; p_d = ed;
    p_word = 32'((dv - 4) / 2) | (32'(vp) << 20) | (32'(hp) << 21) | (32'(ed) << 22);
    step();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset and idle state
    tag_force = "R1";
    run(3);
    @(negedge clk);
    rst_n = 1'b1;
    run(6);

    // Config A: 23-tick lines, 8-line frames, divide by 4, active-low syncs
    wr_h(2, 3, 16, 2);
    wr_v(1, 2, 4, 1);
    wr_c(4, 0, 0, 0);
    run(3);
    tag_force = "";
    wr_ctrl(1, 1);
    run(2 * 736 + 10);

    // R9: mid-frame rewrite to config B, which only the next frame may use
    run(300);
    tag_force = "R9";
    wr_h(1, 1, 16, 1);
    wr_v(2, 0, 2, 0);
    wr_c(6, 1, 1, 1);
    run(800);
    tag_force = "";
    run(500);

    // R1: stop mid-frame
    tag_force = "R1";
    wr_ctrl(0, 1);
    run(20);

    // Config C: mixed polarity, divide by 8, passive mode
    wr_h(3, 2, 20, 4);
    wr_v(1, 1, 3, 2);
    wr_c(8, 1, 0, 0);
    run(3);
    tag_force = "";
    wr_ctrl(1, 0);
    run(1700);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule